// File: doc/BRIEF.md
# Card Presence Sequencer

This block watches an active-low card-present input that tells a power controller whether a plug-in card is seated. The input is brought into the clock domain through a chain of synchroniser flops. The block reports the synchronised level as a live status bit and latches every transition into a sticky change flag. Removal switches off the switch-enable bits straight away. Insertion sends a one-cycle clear pulse to the neighbouring fault loggers and starts a qualification timer. When the card has stayed seated for the whole qualification window, the level of a power-on request input is loaded into the enable bits.

A sequence-mode control input picks how the enables are loaded. With the mode off, every enable bit takes the power-on level. With the mode on, only enable bit 0 takes it, and the upper enable bits are wiped when the card is inserted. Staging those upper bits is left to a separate sequencer. The enable bits can also be written directly through a plain write strobe. Every pin is a plain control or status pin: the block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `cardseq_top`

## Requirements
- R1: `present_n_status` equals the level of `card_sel_n` delayed by the synchroniser, two clock edges with the default depth. It reads 1 while no card is seated.
- R2: Every rising or falling synchronised transition sets `sel_changed`. The flag stays set until a cycle with `changed_clr` high and no transition. A transition wins over a clear in the same cycle.
- R3: A synchronised rising transition (removal) drives all `sw_en` bits to 0 at the next clock edge, whatever else happens in that cycle.
- R4: A synchronised falling transition (insertion) makes `fault_clr` high for exactly one cycle, at the same edge that sets `sel_changed`.
- R5: On insertion with `seq_mode`=1, `sw_en[3:1]` are cleared and `sw_en[0]` keeps its value. With `seq_mode`=0 the enables are left unchanged.
- R6: If the card stays seated for QUAL_CYCLES clock edges after the insertion edge, all `sw_en` bits take the synchronised `on_req` level when `seq_mode`=0.
- R7: At that same capture point with `seq_mode`=1, only `sw_en[0]` takes `on_req`, and `sw_en[3:1]` keep their values.
- R8: A removal before the window expires abandons the capture. The next insertion restarts a full window of QUAL_CYCLES edges.
- R9: `en_wr` loads `en_wdata` into `sw_en` at the next edge, unless a removal, an insertion or a capture occurs in that cycle. Those events take priority.
- R10: After reset, `sw_en`=0, `sel_changed`=0, `fault_clr`=0 and `present_n_status`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_sel_n | input | 1 | Asynchronous card-present input, low when a card is seated |
| on_req | input | 1 | Power-on request level, captured after qualification |
| seq_mode | input | 1 | 1: capture into enable bit 0 only and wipe the upper bits on insertion |
| changed_clr | input | 1 | Clears the sticky change flag |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | NUM_EN | Value written into the enable bits |
| sw_en | output | NUM_EN | Switch-enable control bits |
| sel_changed | output | 1 | Sticky flag: the card-present input has toggled |
| present_n_status | output | 1 | Live synchronised card-present level |
| fault_clr | output | 1 | One-cycle pulse that clears the other fault bits on insertion |

## Verification
A stale synchroniser or edge register shows at `present_n_status` and `sel_changed` within three cycles of a toggle. A fault in the qualification counter moves the cycle in which `sw_en` takes `on_req`, earlier or later than exactly QUAL_CYCLES edges after insertion. It can also make `sw_en` change after an aborted insertion. A wrong priority in the enable register shows up only in the one cycle where a write meets a removal, an insertion or a capture. For that reason `sw_en` is compared every cycle against an independent model, and short windows make each of these cycles happen several times.

// File: rtl/cardseq_pkg.sv
package cardseq_pkg;
  // Synchronised view of the card-present pin for one cycle
  typedef struct packed {
    logic level;  // 1 = no card
    logic rise;   // removal seen this cycle
    logic fall;   // insertion seen this cycle
  } sel_evt_t;
endpackage

// File: rtl/cardseq_sync.sv
module cardseq_sync #(
  parameter int       WIDTH   = 1,
  parameter int       STAGES  = 2,
  parameter bit [0:0] RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= {WIDTH{RST_VAL}};
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= {WIDTH{RST_VAL}};
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cardseq_edge.sv
module cardseq_edge
  import cardseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  input  logic     changed_clr,
  output sel_evt_t evt,
  output logic     sel_changed,
  output logic     fault_clr
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;

  assign evt.level = lvl;
  assign evt.rise  = lvl & ~prev_q;
  assign evt.fall  = ~lvl & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_changed <= 1'b0;
      fault_clr   <= 1'b0;
    end else begin
      fault_clr <= evt.fall;
      if (evt.rise || evt.fall) sel_changed <= 1'b1;
      else if (changed_clr)     sel_changed <= 1'b0;
    end
  end

  assert_toggle_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.rise || evt.fall) |=> sel_changed);
  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_changed && !changed_clr) |=> sel_changed);
  assert_clr_after_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall |=> fault_clr);
  assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !fault_clr);
endmodule

// File: rtl/cardseq_qual_timer.sv
module cardseq_qual_timer
  import cardseq_pkg::*;
#(
  parameter int QUAL_CYCLES = 5_000_000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sel_evt_t evt,
  output logic     capture
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  assign capture = armed_q && (cnt_q == LAST) && !evt.rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (evt.rise) begin
      armed_q <= 1'b0;
    end else if (evt.fall) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (capture) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_abort_on_removal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> !armed_q);
  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (cnt_q <= LAST));
  assert_capture_needs_card_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !evt.level);
endmodule

// File: rtl/cardseq_enable_reg.sv
module cardseq_enable_reg
  import cardseq_pkg::*;
#(
  parameter int NUM_EN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_evt_t          evt,
  input  logic              capture,
  input  logic              seq_mode,
  input  logic              on_lvl,
  input  logic              en_wr,
  input  logic [NUM_EN-1:0] en_wdata,
  output logic [NUM_EN-1:0] en
);
  localparam int UPPER = NUM_EN - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else if (evt.rise) begin
      en <= '0;
    end else if (evt.fall) begin
      if (seq_mode) en[NUM_EN-1:1] <= '0;
    end else if (capture) begin
      if (seq_mode) en[0] <= on_lvl;
      else          en    <= {NUM_EN{on_lvl}};
    end else if (en_wr) begin
      en <= en_wdata;
    end
  end

  assert_seq_insert_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.fall && seq_mode) |=> (en[NUM_EN-1:1] == {UPPER{1'b0}}));
  assert_seq_insert_keeps_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall |=> (en[0] == $past(en[0])));
endmodule

// File: rtl/cardseq_top.sv
module cardseq_top
  import cardseq_pkg::*;
#(
  parameter int QUAL_CYCLES = 5_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_EN      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_sel_n,
  input  logic              on_req,
  input  logic              seq_mode,
  input  logic              changed_clr,
  input  logic              en_wr,
  input  logic [NUM_EN-1:0] en_wdata,
  output logic [NUM_EN-1:0] sw_en,
  output logic              sel_changed,
  output logic              present_n_status,
  output logic              fault_clr
);
  sel_evt_t evt;
  logic     sel_lvl;
  logic     on_lvl;
  logic     capture;

  cardseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(card_sel_n), .q(sel_lvl)
  );

  cardseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_on_sync (
    .clk(clk), .rst_n(rst_n), .d(on_req), .q(on_lvl)
  );

  cardseq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .changed_clr(changed_clr),
    .evt(evt), .sel_changed(sel_changed), .fault_clr(fault_clr)
  );

  cardseq_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .evt(evt), .capture(capture)
  );

  cardseq_enable_reg #(.NUM_EN(NUM_EN)) u_en (
    .clk(clk), .rst_n(rst_n), .evt(evt), .capture(capture),
    .seq_mode(seq_mode), .on_lvl(on_lvl), .en_wr(en_wr),
    .en_wdata(en_wdata), .en(sw_en)
  );

  assign present_n_status = evt.level;

  initial begin
    assert_params_ok_R6: assert (QUAL_CYCLES >= 2 && SYNC_STAGES >= 2 && NUM_EN >= 2);
  end

  assert_removal_kills_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> (sw_en == '0));
  assert_capture_only_when_seated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !present_n_status);
  assert_status_follows_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(present_n_status) |-> (sel_changed || evt.rise || evt.fall));
endmodule

// File: tb/sim_cardseq_top.sv
module sim_cardseq_top;
  localparam int Q  = 20;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          card_sel_n = 1'b1;
  logic          on_req = 1'b0;
  logic          seq_mode = 1'b0;
  logic          changed_clr = 1'b0;
  logic          en_wr = 1'b0;
  logic [NE-1:0] en_wdata = '0;
  logic [NE-1:0] sw_en;
  logic          sel_changed, present_n_status, fault_clr;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  cardseq_top #(.QUAL_CYCLES(Q), .SYNC_STAGES(2), .NUM_EN(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .card_sel_n(card_sel_n), .on_req(on_req),
    .seq_mode(seq_mode), .changed_clr(changed_clr), .en_wr(en_wr),
    .en_wdata(en_wdata), .sw_en(sw_en), .sel_changed(sel_changed),
    .present_n_status(present_n_status), .fault_clr(fault_clr)
  );

  // Behavioural reference: delay lines as queues, timer as a countdown
  bit       sel_hist[$];
  bit       on_hist[$];
  bit [3:0] m_en;
  bit       m_chg, m_clr, m_stat;
  int       m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      sel_hist = '{1'b1, 1'b1, 1'b1};
      on_hist  = '{1'b0, 1'b0, 1'b0};
      m_en = '0; m_chg = 0; m_clr = 0; m_stat = 1; m_left = 0;
    end else begin
      bit now_lvl, old_lvl, ins, rem, cap, onv;
      now_lvl = sel_hist[1];
      old_lvl = sel_hist[2];
      rem = now_lvl && !old_lvl;
      ins = !now_lvl && old_lvl;
      onv = on_hist[1];
      cap = (m_left == 1) && !rem;
      m_clr = ins;
      if (rem || ins) m_chg = 1; else if (changed_clr) m_chg = 0;
      if (rem) m_en = '0;
      else if (ins) begin if (seq_mode) m_en[3:1] = '0; end
      else if (cap) begin if (seq_mode) m_en[0] = onv; else m_en = {4{onv}}; end
      else if (en_wr) m_en = en_wdata;
      if (rem) m_left = 0;
      else if (ins) m_left = Q;
      else if (cap) m_left = 0;
      else if (m_left > 1) m_left--;
      sel_hist.push_front(card_sel_n); void'(sel_hist.pop_back());
      on_hist.push_front(on_req);      void'(on_hist.pop_back());
      m_stat = sel_hist[1];
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (present_n_status !== m_stat) begin misses++;
        $display("FAIL R1 status act=%0b exp=%0b t=%0t", present_n_status, m_stat, $time); end
      if (sel_changed !== m_chg) begin misses++;
        $display("FAIL R2 changed act=%0b exp=%0b t=%0t", sel_changed, m_chg, $time); end
      if (fault_clr !== m_clr) begin misses++;
        $display("FAIL R4 fault_clr act=%0b exp=%0b t=%0t", fault_clr, m_clr, $time); end
      if (sw_en !== m_en) begin misses++;
        $display("FAIL R3/R5/R6/R7/R8/R9 sw_en act=%b exp=%b t=%0t", sw_en, m_en, $time); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic wr_en(input logic [NE-1:0] v);
    en_wr = 1; en_wdata = v; cyc(1); en_wr = 0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    cyc(3);
    @(negedge clk);
    // R10 reset state
    chk("R10 sw_en", sw_en, 0);
    chk("R10 changed", sel_changed, 0);
    chk("R10 fault_clr", fault_clr, 0);
    chk("R10 status", present_n_status, 1);
    @(posedge clk); #3; rst_n = 1;
    cyc(2);

    // R9 write while card absent
    wr_en(4'b1111); cyc(1);
    @(negedge clk); chk("R9 write", sw_en, 4'hF);

    // R4 R6 insertion, mode 0, on_req low -> all enables drop after window
    on_req = 0; seq_mode = 0; card_sel_n = 0;
    cyc(3); @(negedge clk);
    chk("R1 status low", present_n_status, 0);
    chk("R5 mode0 keeps", sw_en, 4'hF);
    cyc(Q + 2); @(negedge clk);
    chk("R6 capture all", sw_en, 0);
    chk("R2 sticky", sel_changed, 1);
    changed_clr = 1; cyc(1); changed_clr = 0; cyc(1);
    @(negedge clk); chk("R2 cleared", sel_changed, 0);

    // R3 removal with enables on
    wr_en(4'b1111); cyc(1);
    card_sel_n = 1; cyc(4); @(negedge clk);
    chk("R3 off", sw_en, 0);

    // R5 R7 mode 1 insertion: upper bits wiped, bit0 kept, then bit0 captured
    wr_en(4'b0111); seq_mode = 1; on_req = 0; cyc(1);
    card_sel_n = 0; cyc(4); @(negedge clk);
    chk("R5 upper wiped", sw_en, 4'b0001);
    wr_en(4'b1111);
    cyc(Q + 2); @(negedge clk);
    chk("R7 bit0 only", sw_en, 4'b1110);

    // R8 aborted window, then restart
    seq_mode = 0; on_req = 1; card_sel_n = 1; cyc(5);
    card_sel_n = 0; cyc(Q / 2);
    card_sel_n = 1; cyc(4);
    wr_en(4'b0000); cyc(Q);
    @(negedge clk); chk("R8 no capture", sw_en, 0);
    card_sel_n = 0; cyc(Q - 2);
    @(negedge clk); chk("R8 not yet", sw_en, 0);
    cyc(6); @(negedge clk); chk("R8 restart capture", sw_en, 4'hF);

    // R9 write collides with removal: removal wins
    card_sel_n = 1; cyc(1); cyc(1);
    en_wr = 1; en_wdata = 4'b1010; cyc(1); en_wr = 0; cyc(1);
    @(negedge clk); chk("R9 removal priority", sw_en, 0);

    // R2 clear and toggle in the same cycle, plus a one-cycle glitch
    changed_clr = 1; card_sel_n = 0; cyc(1); card_sel_n = 1; cyc(3); changed_clr = 0;
    cyc(2); @(negedge clk); chk("R2 toggle wins", sel_changed, 1);

    cyc(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule